// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models a byte-wide parallel NOR flash as seen from a processor bus. Reads return array contents, a two-byte device identifier, or a fixed filler value, depending on the current mode. Writes pass through a three-step unlock decoder. An unlock prefix that is broken off is replayed as ordinary data writes. Data writes in normal mode collect in a page buffer. When no write has arrived for a programmable number of clocks, the buffer is copied into the array one byte per clock.

The device can occupy both byte lanes of a 16-bit bus, or only the even lane, or only the odd lane. A word access is handled as two byte accesses in one clock. The even (high) byte goes first and the odd (low) byte second. Erase, protection control and real boot-block protection are accepted as codes but do nothing.

Top module: `nor_cmd_flash`

## Requirements
- R1: Unlock step one is data 0xAA at device offset 0x5555 and step two is 0x55 at 0x2AAA. Step three is a command byte at 0x5555. Every offset is taken modulo the array size, so with a 256-byte array the offsets are 0x55 and 0xAA.
- R2: If step two fails to match, the block performs a data write of 0xAA to 0x5555, then a data write of the current byte. It then returns to the idle step.
- R3: If the step-three offset differs from 0x5555, the block performs data writes of 0xAA to 0x5555, 0x55 to 0x2AAA and the current byte, in that order. It then returns to the idle step.
- R4: In the primary set, command 0x90 enters identifier mode and 0xF0 enters normal mode. Command 0x80 arms the alternate set for the next command. Any other code, including 0xA0 and 0x10, has no effect.
- R5: With the alternate set armed, 0x40 enters boot-block mode and 0x60 enters identifier mode, while 0x10, 0x20 and other codes change nothing. Any completed command disarms the alternate set.
- R6: In identifier mode, offset 0 reads the identifier high byte and offset 1 reads the low byte. Every other offset reads 0xFE. Every read in boot-block mode returns 0xFF.
- R7: A data write in normal mode stores its byte in the page buffer at the offset modulo the page size, and marks a commit as pending. The page base is taken from the write offset with the page bits cleared, but only when a commit was already pending before that write. Otherwise the previous base is kept.
- R8: Once a commit is pending and IDLE_CYCLES clocks pass with no data write, the page buffer is copied into the array at the page base, one byte per clock. Every copied slot refills with 0xFF, and the pending mark clears. Before the copy, the array keeps its old value.
- R9: A data write in boot-block mode stores nothing and returns the block to normal mode. A data write in identifier mode is ignored.
- R10: When LANE is 1 (even lane only) or 2 (odd lane only), a byte on the other lane reads 0xFF and its writes are ignored without disturbing the unlock sequence. The bus address is shifted right by one to form the device offset.
- R11: A word access handles the even address (data bits 15:8) before the odd address (bits 7:0). A byte read returns 0xFF in bits 15:8 and the byte in bits 7:0. Read data appears in the clock after the read and holds until the next read.
- R12: After reset the block is in normal mode, the read data is 0 and the array and page buffer hold 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ARRAY_AW, or ARRAY_AW+1 for one lane | Byte address on the bus |
| wr_en | input | 1 | Write strobe for this clock |
| rd_en | input | 1 | Read strobe for this clock |
| word_en | input | 1 | Access is a 16-bit word at an even address |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with a 256-byte array, 16-byte pages and a 40-clock idle interval. With these values the unlock offsets shrink to 0x55 and 0xAA, and several page commits fit into a short run. Because the pages are small, one test can show a commit overwriting untouched slots with 0xFF, and another can show a commit landing on a stale page base. A second instance built for the even lane only checks that the address is halved, and that odd-lane bytes neither read back nor break an unlock in progress.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int ARRAY_AW = 11,
  parameter int PAGE_AW = 6,
  parameter int IDLE_CYCLES = 10690,
  parameter int LANE = 0,
  parameter logic [15:0] PROD_ID = 16'hC3A5,
  localparam int BUS_AW = (LANE == 0) ? ARRAY_AW : ARRAY_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              word_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam int ARRAY_SZ = 1 << ARRAY_AW;
  localparam int PAGE_SZ = 1 << PAGE_AW;
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [ARRAY_AW-1:0] KEY_A = ARRAY_AW'(32'h5555);
  localparam logic [ARRAY_AW-1:0] KEY_B = ARRAY_AW'(32'h2AAA);
  localparam logic [ARRAY_AW-1:0] PG_MASK = ARRAY_AW'(PAGE_SZ - 1);
  localparam logic [1:0] M_NORM = 2'd0, M_ID = 2'd1, M_BOOT = 2'd2;
  localparam logic [1:0] S_IDLE = 2'd0, S_ONE = 2'd1, S_TWO = 2'd2;

  logic [1:0] mode, seq;
  logic alt, pending, copying;
  logic [7:0] arr [ARRAY_SZ];
  logic [7:0] pbuf [PAGE_SZ];
  logic [ARRAY_AW-1:0] base;
  logic [PAGE_AW-1:0] cidx;
  logic [CNT_W-1:0] quiet;

  logic [1:0] n_mode, n_seq;
  logic n_alt, n_pend, wrote;
  logic [ARRAY_AW-1:0] n_base;
  logic [7:0] n_pbuf [PAGE_SZ];

  function automatic logic lane_ok(input logic [BUS_AW-1:0] a);
    return (LANE == 0) || (LANE == 1 && !a[0]) || (LANE == 2 && a[0]);
  endfunction

  function automatic logic [ARRAY_AW-1:0] dev_of(input logic [BUS_AW-1:0] a);
    logic [BUS_AW-1:0] s;
    s = (LANE == 0) ? a : (a >> 1);
    return s[ARRAY_AW-1:0];
  endfunction

  function automatic logic [7:0] rd_byte(input logic [BUS_AW-1:0] a);
    logic [ARRAY_AW-1:0] d;
    d = dev_of(a);
    if (!lane_ok(a)) return 8'hFF;
    case (mode)
      M_NORM: return arr[d];
      M_ID: return (d == '0) ? PROD_ID[15:8] :
                   (d == ARRAY_AW'(1)) ? PROD_ID[7:0] : 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  always_comb begin
    logic [BUS_AW-1:0] ba;
    logic [7:0] bv;
    logic [ARRAY_AW-1:0] da;
    logic [ARRAY_AW-1:0] wa [3];
    logic [7:0] wv [3];
    int wn;
    ba = '0; bv = '0; da = '0; wn = 0;
    for (int j = 0; j < 3; j++) begin wa[j] = '0; wv[j] = '0; end
    n_mode = mode; n_seq = seq; n_alt = alt; n_pend = pending; n_base = base;
    wrote = 1'b0;
    for (int i = 0; i < PAGE_SZ; i++) n_pbuf[i] = pbuf[i];
    if (copying) n_pbuf[cidx] = 8'hFF;
    if (wr_en) begin
      for (int k = 0; k < 2; k++) begin
        if (k == 0 || word_en) begin
          ba = word_en ? {bus_addr[BUS_AW-1:1], 1'(k)} : bus_addr;
          bv = (word_en && k == 0) ? wdata[15:8] : wdata[7:0];
          wn = 0;
          if (lane_ok(ba)) begin
            da = dev_of(ba);
            case (n_seq)
              S_IDLE: begin
                if (bv == 8'hAA && da == KEY_A) n_seq = S_ONE;
                else begin wa[0] = da; wv[0] = bv; wn = 1; end
              end
              S_ONE: begin
                n_seq = S_IDLE;
                if (bv == 8'h55 && da == KEY_B) n_seq = S_TWO;
                else begin
                  wa[0] = KEY_A; wv[0] = 8'hAA;
                  wa[1] = da; wv[1] = bv; wn = 2;
                end
              end
              default: begin
                n_seq = S_IDLE;
                if (da == KEY_A) begin
                  if (n_alt) begin
                    n_alt = 1'b0;
                    if (bv == 8'h40) n_mode = M_BOOT;
                    else if (bv == 8'h60) n_mode = M_ID;
                  end else begin
                    case (bv)
                      8'h80: n_alt = 1'b1;
                      8'h90: n_mode = M_ID;
                      8'hF0: n_mode = M_NORM;
                      default: ;
                    endcase
                  end
                end else begin
                  wa[0] = KEY_A; wv[0] = 8'hAA;
                  wa[1] = KEY_B; wv[1] = 8'h55;
                  wa[2] = da; wv[2] = bv; wn = 3;
                end
              end
            endcase
            for (int j = 0; j < 3; j++) begin
              if (j < wn) begin
                if (n_mode == M_NORM) begin
                  if (n_pend) n_base = wa[j] & ~PG_MASK;
                  n_pbuf[wa[j][PAGE_AW-1:0]] = wv[j];
                  n_pend = 1'b1;
                  wrote = 1'b1;
                end else if (n_mode == M_BOOT) begin
                  n_mode = M_NORM;
                end
              end
            end
          end
        end
      end
    end
    if (copying && cidx == PAGE_AW'(PAGE_SZ - 1) && !wrote) n_pend = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_NORM; seq <= S_IDLE; alt <= 1'b0;
      pending <= 1'b0; copying <= 1'b0; cidx <= '0; quiet <= '0;
      base <= '0; rdata <= '0;
      for (int i = 0; i < PAGE_SZ; i++) pbuf[i] <= 8'hFF;
      for (int i = 0; i < ARRAY_SZ; i++) arr[i] <= 8'hFF;
    end else begin
      mode <= n_mode; seq <= n_seq; alt <= n_alt;
      pending <= n_pend; base <= n_base;
      for (int i = 0; i < PAGE_SZ; i++) pbuf[i] <= n_pbuf[i];
      if (rd_en)
        rdata <= word_en ? {rd_byte({bus_addr[BUS_AW-1:1], 1'b0}),
                            rd_byte({bus_addr[BUS_AW-1:1], 1'b1})}
                         : {8'hFF, rd_byte(bus_addr)};
      if (wrote) quiet <= '0;
      else if (pending && !copying && quiet != CNT_W'(IDLE_CYCLES)) quiet <= quiet + 1'b1;
      if (copying) begin
        arr[base | ARRAY_AW'(cidx)] <= pbuf[cidx];
        cidx <= cidx + 1'b1;
        if (cidx == PAGE_AW'(PAGE_SZ - 1)) copying <= 1'b0;
      end else if (pending && !wrote && quiet == CNT_W'(IDLE_CYCLES)) begin
        copying <= 1'b1;
        cidx <= '0;
      end
    end
  end

  p_pend_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrote |=> pending);
  p_copy_only_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    copying |-> pending);
  p_array_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !copying |=> $stable(arr[0]));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  p_seq_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_TWO && wr_en && !word_en && lane_ok(bus_addr)) |=> seq == S_IDLE);
endmodule

// File: tb/nor_cmd_flash_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_flash_tb_top;
  localparam int AW = 8;
  localparam int PSZ = 16;
  localparam int IDLE = 40;
  localparam logic [15:0] ID = 16'hC3A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] addr = '0;
  logic wr_en = 0, rd_en = 0, word_en = 0;
  logic [15:0] wdata = '0, rdata;
  logic [8:0] l_addr = '0;
  logic l_wr = 0, l_rd = 0, l_word = 0;
  logic [15:0] l_wdata = '0, l_rdata;

  nor_cmd_flash #(.ARRAY_AW(AW), .PAGE_AW(4), .IDLE_CYCLES(IDLE), .LANE(0), .PROD_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .word_en(word_en), .wdata(wdata), .rdata(rdata));
  nor_cmd_flash #(.ARRAY_AW(AW), .PAGE_AW(4), .IDLE_CYCLES(IDLE), .LANE(1), .PROD_ID(ID)) lane_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(l_addr), .wr_en(l_wr), .rd_en(l_rd),
    .word_en(l_word), .wdata(l_wdata), .rdata(l_rdata));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int m_arr [256];
  int m_buf [PSZ];
  int m_mode = 0, m_seq = 0, m_alt = 0, m_base = 0, m_pend = 0, m_last = 0, m_edge = 0;
  logic [15:0] m_rd = '0;
  string cur_tag = "R12 reset";

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic m_dw(input int d, input int v);
    if (m_mode == 0) begin
      if (m_pend != 0) m_base = d & 'hF0;
      m_buf[d % PSZ] = v;
      m_pend = 1;
      m_last = m_edge;
    end else if (m_mode == 2) m_mode = 0;
  endtask

  task automatic m_run();
    if (m_pend != 0 && m_edge > m_last + IDLE + 1 + PSZ) begin
      for (int i = 0; i < PSZ; i++) begin
        m_arr[m_base + i] = m_buf[i];
        m_buf[i] = 'hFF;
      end
      m_pend = 0;
    end
  endtask

  task automatic m_wbyte(input int a, input int v);
    int d;
    d = a & 'hFF;
    if (m_seq == 0) begin
      if (v == 'hAA && d == 'h55) m_seq = 1; else m_dw(d, v);
    end else if (m_seq == 1) begin
      m_seq = 0;
      if (v == 'h55 && d == 'hAA) m_seq = 2;
      else begin m_dw('h55, 'hAA); m_dw(d, v); end
    end else begin
      m_seq = 0;
      if (d == 'h55) begin
        if (m_alt != 0) begin
          m_alt = 0;
          if (v == 'h40) m_mode = 2; else if (v == 'h60) m_mode = 1;
        end else if (v == 'h80) m_alt = 1;
        else if (v == 'h90) m_mode = 1;
        else if (v == 'hF0) m_mode = 0;
      end else begin
        m_dw('h55, 'hAA); m_dw('hAA, 'h55); m_dw(d, v);
      end
    end
  endtask

  function automatic logic [7:0] rb(input int a);
    int d;
    d = a & 'hFF;
    if (m_mode == 0) return 8'(m_arr[d]);
    if (m_mode == 1) return (d == 0) ? ID[15:8] : (d == 1) ? ID[7:0] : 8'hFE;
    return 8'hFF;
  endfunction

  task automatic acc(input bit wr, input bit wd, input int a, input int d, input string tag);
    @(negedge clk);
    addr = 8'(a); wr_en = wr; rd_en = !wr; word_en = wd; wdata = 16'(d);
    m_edge = cyc + 1;
    m_run();
    if (!wr) m_rd = wd ? {rb(a & ~1), rb(a | 1)} : {8'hFF, rb(a)};
    else if (wd) begin m_wbyte(a & ~1, (d >> 8) & 'hFF); m_wbyte(a | 1, d & 'hFF); end
    else m_wbyte(a, d & 'hFF);
    cur_tag = tag;
    @(negedge clk);
    wr_en = 0; rd_en = 0; word_en = 0;
    chk(rdata, m_rd, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk(rdata, m_rd, {cur_tag, " hold R11"});
    end
  endtask

  task automatic unlock(input int cmd, input string tag);
    acc(1, 0, 'h55, 'hAA, tag);
    acc(1, 0, 'hAA, 'h55, tag);
    acc(1, 0, 'h55, cmd, tag);
  endtask

  task automatic lacc(input bit wr, input bit wd, input int a, input int d,
                      input logic [15:0] exp, input string tag);
    @(negedge clk);
    l_addr = 9'(a); l_wr = wr; l_rd = !wr; l_word = wd; l_wdata = 16'(d);
    @(negedge clk);
    l_wr = 0; l_rd = 0; l_word = 0;
    if (!wr) chk(l_rdata, exp, tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_arr[i] = 'hFF;
    for (int i = 0; i < PSZ; i++) m_buf[i] = 'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata, 16'h0000, "R12 rdata after reset");
    acc(0, 1, 'h00, 0, "R12 erased array");

    acc(1, 0, 'h03, 'h11, "R7 write");
    acc(1, 0, 'h04, 'h22, "R7 write");
    acc(0, 0, 'h03, 0, "R8 array unchanged before commit");
    idle(70);
    acc(0, 1, 'h02, 0, "R8 committed word");
    acc(0, 0, 'h04, 0, "R8 committed byte");

    unlock('h90, "R1 enter id");
    acc(0, 1, 'h00, 0, "R6 id bytes");
    acc(0, 0, 'h02, 0, "R6 id filler");
    acc(1, 0, 'h07, 'h33, "R9 id write");
    unlock('hF0, "R4 back to normal");
    idle(70);
    acc(0, 0, 'h07, 0, "R9 id write ignored");

    unlock('h80, "R4 arm alternate");
    unlock('h40, "R5 boot mode");
    acc(0, 1, 'h00, 0, "R6 boot read");
    acc(1, 0, 'h05, 'h44, "R9 boot write");
    acc(0, 0, 'h03, 0, "R9 boot write exits");
    idle(70);
    acc(0, 0, 'h05, 0, "R9 boot write not stored");

    unlock('h80, "R5 arm");
    unlock('h60, "R5 alt id");
    acc(0, 1, 'h00, 0, "R5 alt id read");
    unlock('hF0, "R5 alternate cleared");
    acc(0, 0, 'h03, 0, "R5 normal again");

    unlock('hA0, "R4 no-op code");
    unlock('h10, "R4 unknown code");
    acc(0, 0, 'h03, 0, "R4 still normal");

    acc(1, 0, 'h55, 'hAA, "R2 step one");
    acc(1, 0, 'h20, 'h12, "R2 broken step two");
    idle(70);
    acc(0, 1, 'h20, 0, "R2 replay word");
    acc(0, 0, 'h25, 0, "R2 replayed key");

    acc(1, 0, 'h55, 'hAA, "R3 step one");
    acc(1, 0, 'hAA, 'h55, "R3 step two");
    acc(1, 0, 'h31, 'h77, "R3 broken step three");
    idle(70);
    acc(0, 1, 'h30, 0, "R3 replay word");
    acc(0, 0, 'h35, 0, "R3 replay key a");
    acc(0, 0, 'h3A, 0, "R3 replay key b");

    acc(1, 0, 'h47, 'h66, "R7 lone write");
    idle(70);
    acc(0, 0, 'h37, 0, "R7 stale base");
    acc(0, 0, 'h47, 0, "R7 not at own page");
    acc(0, 0, 'h31, 0, "R8 untouched slot refilled");

    acc(1, 1, 'h54, 'h9CAA, "R11 word unlock");
    acc(1, 1, 'hAA, 'h553E, "R11 word broken");
    idle(70);
    acc(0, 1, 'hAA, 0, "R11 order low");
    acc(0, 1, 'hA4, 0, "R11 order high");
    acc(1, 1, 'h50, 'hABCD, "R11 word write");
    idle(70);
    acc(0, 1, 'h50, 0, "R11 word readback");

    lacc(1, 0, 'h0AA, 'hAA, 16'h0, "R10 lane");
    lacc(1, 0, 'h154, 'h55, 16'h0, "R10 lane");
    lacc(1, 0, 'h0AA, 'h90, 16'h0, "R10 lane");
    lacc(0, 1, 'h000, 0, {ID[15:8], 8'hFF}, "R10 even lane id");
    lacc(0, 0, 'h001, 0, 16'hFFFF, "R10 odd byte reads FF");
    lacc(1, 0, 'h0AA, 'hAA, 16'h0, "R10 lane");
    lacc(1, 0, 'h101, 'h12, 16'h0, "R10 odd write ignored");
    lacc(1, 0, 'h154, 'h55, 16'h0, "R10 lane");
    lacc(1, 0, 'h0AA, 'hF0, 16'h0, "R10 lane");
    lacc(0, 1, 'h000, 0, 16'hFFFF, "R10 sequence intact");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog R12 got %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule